// File: doc/BRIEF.md
# Nine-Bit Serial Command/Data Receiver

This block is the receive side of a three-wire serial link: an active-low frame enable, a serial clock and a serial data line. Each packet is nine bits long. The first bit is a kind flag and the next eight are a byte, sent most significant bit first. A flag of 0 makes the byte a command, which leaves the block on a command output with a one-cycle valid strobe. A flag of 1 makes the byte display data. Display data is written through a memory write port at the address held in an internal counter, and the counter then advances by one.

All three link lines are asynchronous to the system clock. Each passes through a two-stage synchronizer, and serial clock edges are found in the system clock domain. The system clock must run at least four times faster than the serial clock. While the enable stays low, packets follow each other with no gap. An active-low asynchronous reset aborts any packet in progress and clears all state. A separate load port with its own strobe sets the write address.

Top module: `serial_pkt_rx`

## Requirements
- R1: After reset, `cmd_valid_o` and `mem_we_o` are 0, `cmd_byte_o` and `mem_wdata_o` are 0, and `mem_addr_o` is 0.
- R2: While `sce_i` is high, rising edges of `sclk_i` produce no strobe and leave no partial packet behind.
- R3: A packet whose flag bit is 0 raises `cmd_valid_o` for one cycle with the received byte on `cmd_byte_o`, and it raises no memory write.
- R4: A packet whose flag bit is 1 raises `mem_we_o` for one cycle with the byte on `mem_wdata_o`. While `mem_we_o` is high, `mem_addr_o` holds the address being written.
- R5: A packet takes exactly nine rising edges of `sclk_i`, sampled from `sdata_i`. The first edge carries the flag, and edges two to nine carry byte bits 7 down to 0.
- R6: After a data write, `mem_addr_o` increases by one. A command packet leaves `mem_addr_o` unchanged.
- R7: While `sce_i` stays low, the rising edge after the ninth bit is taken as the flag of the next packet.
- R8: If `sce_i` rises before a packet is complete, the packet is dropped with no strobe, and the next frame starts again with a flag bit.
- R9: Asserting `rst_n` low in the middle of a packet aborts it and clears the address. If `sce_i` is low when reset is released, the next rising `sclk_i` edge is taken as a flag.
- R10: The address counter is `AW` bits wide (11 by default) and wraps from its maximum value to 0 on a data write.
- R11: A high `addr_load_i` at a clock edge sets `mem_addr_o` to `addr_load_val_i`. A load takes priority over an increment in the same cycle.
- R12: `cmd_valid_o` and `mem_we_o` are never high together. Each stays high for exactly one cycle and appears within 3 system clock cycles after the ninth rising `sclk_i` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sce_i | input | 1 | Frame enable, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| addr_load_i | input | 1 | Load strobe for the write address |
| addr_load_val_i | input | AW | Value to load into the address |
| cmd_valid_o | output | 1 | One-cycle strobe for a received command byte |
| cmd_byte_o | output | 8 | Received command byte |
| mem_we_o | output | 1 | One-cycle display memory write strobe |
| mem_addr_o | output | AW | Current display memory address |
| mem_wdata_o | output | 8 | Display memory write data |

## Verification
A bit counter that is off by one shows up quickly at the ports. Every following byte comes out shifted, or with the wrong kind, starting at the first strobe after the fault, which is within nine serial clock edges. A kind flag that is inverted or latched at the wrong time sends a byte out on the wrong strobe. An address that was not cleared, stepped or loaded correctly is visible on `mem_addr_o` during the very next write strobe, and on the idle address one cycle after the event. State left over when the enable rises shows up as a byte corrupted in the first packet of the next frame, or as a strobe where none should appear.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PKT_LEN = BYTE_W + 1;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic { KIND_CMD = 1'b0, KIND_DATA = 1'b1 } pkt_kind_e;

  // Shift one serial bit into the low end of a byte (MSB arrives first).
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                 input logic              b);
    return {cur[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spr_framer.sv
module spr_framer
  import spr_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(PKT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sce_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              cmd_valid,
  output logic              data_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic              frame_active,
  output logic              sclk_rise,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

  logic              sclk_q;
  logic [BYTE_W-1:0] shreg;
  pkt_kind_e         kind;
  logic              take_bit;
  logic              last_bit;

  assign frame_active = ~sce_s;
  assign sclk_rise    = sclk_s & ~sclk_q;
  assign take_bit     = sclk_rise & frame_active;
  assign last_bit     = take_bit && (bit_cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      shreg      <= '0;
      kind       <= KIND_CMD;
      bit_cnt    <= '0;
      byte_out   <= '0;
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      if (!frame_active) begin
        bit_cnt <= '0;
        shreg   <= '0;
        kind    <= KIND_CMD;
      end else if (take_bit) begin
        if (bit_cnt == '0) kind <= pkt_kind_e'(sdata_s);
        else               shreg <= shift_in(shreg, sdata_s);
        if (last_bit) begin
          bit_cnt  <= '0;
          byte_out <= shift_in(shreg, sdata_s);
          if (kind == KIND_DATA) data_valid <= 1'b1;
          else                   cmd_valid  <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spr_addr_ctr.sv
module spr_addr_ctr #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= bump(addr);
  end
endmodule

// File: rtl/serial_pkt_rx.sv
module serial_pkt_rx
  import spr_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sce_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              addr_load_i,
  input  logic [AW-1:0]     addr_load_val_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o
);
  localparam int unsigned SYNC_W = 3;
  localparam int unsigned IX_SCE = 2;
  localparam int unsigned IX_CLK = 1;
  localparam int unsigned IX_DAT = 0;
  localparam int unsigned CNT_W  = $clog2(PKT_LEN);

  logic [SYNC_W-1:0] raw_lines, sync_lines;
  logic              frame_active, sclk_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte;
  logic              cmd_pulse, data_pulse;

  assign raw_lines = {sce_i, sclk_i, sdata_i};

  spr_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  spr_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .sce_s(sync_lines[IX_SCE]), .sclk_s(sync_lines[IX_CLK]), .sdata_s(sync_lines[IX_DAT]),
    .cmd_valid(cmd_pulse), .data_valid(data_pulse), .byte_out(rx_byte),
    .frame_active(frame_active), .sclk_rise(sclk_rise), .bit_cnt(bit_cnt)
  );

  spr_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .inc(data_pulse), .load(addr_load_i),
    .load_val(addr_load_val_i), .addr(mem_addr_o)
  );

  assign cmd_valid_o = cmd_pulse;
  assign cmd_byte_o  = rx_byte;
  assign mem_we_o    = data_pulse;
  assign mem_wdata_o = rx_byte;
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
  parameter int unsigned AW = 11,
  parameter int unsigned CNT_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_load_i,
  input logic [AW-1:0] addr_load_val_i,
  input logic          cmd_valid_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          frame_active,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_excl_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && mem_we_o));
  assert_cmd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  assert_we_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !addr_load_i) |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));
  assert_cmd_keeps_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !addr_load_i) |=> $stable(mem_addr_o));
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load_i |=> (mem_addr_o == $past(addr_load_val_i)));
  assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> (bit_cnt == '0));
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(8));
  assert_strobe_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || mem_we_o) |-> $past(frame_active));
endmodule

bind serial_pkt_rx spr_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_load_val_i(addr_load_val_i),
  .cmd_valid_o(cmd_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .frame_active(frame_active), .bit_cnt(bit_cnt)
);

// File: tb/serial_pkt_rx_test.sv
module serial_pkt_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4 * CLK_PERIOD;
  localparam int AW = 11;
  localparam int NVEC = 8;
  // {flag, byte}
  localparam logic [8:0] VEC [NVEC] = '{9'h0A5, 9'h13C, 9'h1FF, 9'h000,
                                        9'h180, 9'h001, 9'h17E, 9'h0C3};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sce = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic ld = 1'b0;
  logic [AW-1:0] ld_val = '0;
  logic cmd_valid, mem_we;
  logic [7:0] cmd_byte, wdata;
  logic [AW-1:0] maddr;

  int tests = 0, fails = 0;
  int ev_n = 0;
  int ev_kind [64];
  int ev_byte [64];
  int ev_addr [64];
  time ev_time [64];
  time last_rise = 0;
  int overlap = 0, wide = 0;
  logic prev_c = 1'b0, prev_w = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_pkt_rx #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sce_i(sce), .sclk_i(sclk), .sdata_i(sdata),
    .addr_load_i(ld), .addr_load_val_i(ld_val),
    .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte), .mem_we_o(mem_we),
    .mem_addr_o(maddr), .mem_wdata_o(wdata)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid && mem_we) overlap++;
      if ((cmd_valid && prev_c) || (mem_we && prev_w)) wide++;
      if ((cmd_valid || mem_we) && ev_n < 64) begin
        ev_kind[ev_n] = mem_we ? 1 : 0;
        ev_byte[ev_n] = mem_we ? int'(wdata) : int'(cmd_byte);
        ev_addr[ev_n] = int'(maddr);
        ev_time[ev_n] = $time;
        ev_n++;
      end
      prev_c = cmd_valid;
      prev_w = mem_we;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sdata = b;
    #(HALF_SCLK);
    sclk = 1'b1;
    last_rise = $time;
    #(HALF_SCLK);
    sclk = 1'b0;
  endtask

  task automatic spkt(input logic [8:0] p);
    for (int i = 8; i >= 0; i--) sbit(p[i]);
  endtask

  task automatic frame_on();
    sce = 1'b0;
    #(HALF_SCLK);
  endtask

  task automatic frame_off();
    #(HALF_SCLK);
    sce = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic load_addr(input int v);
    @(negedge clk);
    ld = 1'b1;
    ld_val = AW'(v);
    @(negedge clk);
    ld = 1'b0;
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int exp_addr;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!cmd_valid && !mem_we, "R1 strobes", int'(cmd_valid || mem_we), 0);
    check(maddr == 0, "R1 addr", int'(maddr), 0);
    check(cmd_byte == 0 && wdata == 0, "R1 bytes", int'(cmd_byte), 0);

    // Vector table, one frame back to back (R3 R4 R5 R6 R7 R12)
    frame_on();
    foreach (VEC[i]) spkt(VEC[i]);
    frame_off();
    check(ev_n == NVEC, "R7 packet count", ev_n, NVEC);
    exp_addr = 0;
    for (int i = 0; i < NVEC; i++) begin
      check(ev_kind[i] == int'(VEC[i][8]), "R3/R4 kind", ev_kind[i], int'(VEC[i][8]));
      check(ev_byte[i] == int'(VEC[i][7:0]), "R5 byte", ev_byte[i], int'(VEC[i][7:0]));
      if (VEC[i][8]) begin
        check(ev_addr[i] == exp_addr, "R4 write addr", ev_addr[i], exp_addr);
        exp_addr++;
      end
    end
    check(int'(maddr) == exp_addr, "R6 addr after table", int'(maddr), exp_addr);

    // R2: clock edges with enable high are ignored
    base = ev_n;
    for (int i = 0; i < 9; i++) sbit(1'b1);
    repeat (6) @(negedge clk);
    check(ev_n == base, "R2 no strobe while disabled", ev_n - base, 0);

    // R8: incomplete packet dropped, then next frame begins with a flag
    base = ev_n;
    frame_on();
    for (int i = 0; i < 5; i++) sbit(1'b1);
    frame_off();
    check(ev_n == base, "R8 partial dropped", ev_n - base, 0);
    frame_on();
    spkt(9'h05A);
    frame_off();
    check(ev_n == base + 1, "R8 one event", ev_n - base, 1);
    check(ev_kind[base] == 0 && ev_byte[base] == 'h5A, "R8 byte", ev_byte[base], 'h5A);
    check(ev_time[base] - last_rise <= 3 * CLK_PERIOD + CLK_PERIOD / 2,
          "R12 latency", int'(ev_time[base] - last_rise), 3 * CLK_PERIOD);
    // R6 command leaves address
    check(int'(maddr) == exp_addr, "R6 cmd keeps addr", int'(maddr), exp_addr);

    // R9: reset mid-packet, released with enable low
    base = ev_n;
    frame_on();
    for (int i = 0; i < 4; i++) sbit(1'b1);
    #(HALF_SCLK / 2);
    rst_n = 1'b0;
    #(3 * CLK_PERIOD);
    check(maddr == 0, "R9 addr cleared", int'(maddr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    spkt(9'h133);
    frame_off();
    check(ev_n == base + 1, "R9 one event", ev_n - base, 1);
    check(ev_kind[base] == 1 && ev_byte[base] == 'h33, "R9 data byte", ev_byte[base], 'h33);
    check(ev_addr[base] == 0, "R9 write addr", ev_addr[base], 0);

    // R11: load port
    load_addr('h123);
    check(int'(maddr) == 'h123, "R11 loaded", int'(maddr), 'h123);
    base = ev_n;
    frame_on();
    spkt(9'h1C4);
    frame_off();
    check(ev_addr[base] == 'h123, "R11 write at loaded addr", ev_addr[base], 'h123);
    check(int'(maddr) == 'h124, "R6 step after load", int'(maddr), 'h124);

    // R10: wrap
    load_addr((1 << AW) - 1);
    base = ev_n;
    frame_on();
    spkt(9'h111);
    spkt(9'h122);
    frame_off();
    check(ev_addr[base] == (1 << AW) - 1, "R10 top addr", ev_addr[base], (1 << AW) - 1);
    check(ev_addr[base + 1] == 0, "R10 wrapped", ev_addr[base + 1], 0);
    check(int'(maddr) == 1, "R10 after wrap", int'(maddr), 1);

    // R12 strobe shape over the whole run
    check(overlap == 0, "R12 exclusive", overlap, 0);
    check(wide == 0, "R12 single cycle", wide, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule